// File: doc/BRIEF.md
# Multi-Port Reorder Buffer with Same-Cycle Bypass

This block is a circular buffer of completed instructions. Each entry is freed only when it is retired in program order. In every cycle, up to `LANES` completed instructions arrive in any order. Each one is stored in the slot picked by the low bits of its sequence number. In the same cycle, the block retires up to `LANES` entries. It starts at its head pointer and stops at the first entry that is still missing.

The retire decision uses a merged view. This view is the stored valid bits with the current cycle's arrivals already applied, rotated so that the head slot sits at bit 0. As a result, an instruction that arrives in a cycle can retire in that same cycle when it fills the gap at the head, even when the run of entries crosses the end of the buffer.

Retired entries come out packed on the low lanes in program order. A free-slot count lets the upstream selector limit how many instructions it sends.

Top module: `rob_bypass`

## Requirements
- R1: After a synchronous reset, `free_slots` equals `DEPTH`, no lane retires, and the head pointer is slot 0.
- R2: An arriving instruction is stored in the slot given by the low `log2(DEPTH)` bits of `enq_seq`. The upper sequence bits do not select the slot.
- R3: Retire lanes are packed. If `cmt_valid[k]` is set, every lower lane is also set. Lane k carries the entry at slot (head + k) mod `DEPTH`.
- R4: Retiring stops at the first slot, counted from the head, that is neither stored nor arriving in that cycle. No entry beyond that gap retires.
- R5: At most `LANES` entries retire per cycle. `cmt_count` equals the number of set `cmt_valid` bits.
- R6: An entry that arrives in a cycle can retire in that same cycle, with its arriving data, when it completes the run from the head.
- R7: A run that crosses from slot `DEPTH-1` to slot 0 retires in order within a single cycle.
- R8: The head pointer advances by `cmt_count` modulo `DEPTH` at each clock edge.
- R9: `free_slots` equals the number of slots whose stored valid bit is clear.
- R10: Retired entries have their valid bits cleared at the clock edge, so their slots count as free in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enq_valid | input | LANES | Arrival valid, one bit per lane |
| enq_seq | input | LANES x SEQ_W | Sequence number per arrival lane |
| enq_data | input | LANES x DATA_W | Payload per arrival lane |
| cmt_valid | output | LANES | Retire valid, packed from lane 0 |
| cmt_data | output | LANES x DATA_W | Retired payload per lane, in program order |
| cmt_count | output | clog2(LANES+1) | Number of entries retired this cycle |
| free_slots | output | clog2(DEPTH+1) | Number of slots whose stored valid bit is clear |

## Verification
The assertions rely on the block's contract with its inputs:
- Every arriving instruction targets a slot that is currently free.
- No two lanes in one cycle carry the same slot index.

The free-slot bookkeeping property holds only under these two conditions.

The stimulus respects them by construction. It keeps a model of which slots are occupied and draws each arrival only from free slots that no other lane has claimed in that cycle. The upper sequence bits are randomized, which exercises the indexing rule of R2.

// File: rtl/rob_pkg.sv
package rob_pkg;
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/rob_shadow.sv
module rob_shadow #(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned LANES  = 3,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SEQ_W  = 4,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic [DEPTH-1:0]               stored_v,
   input  logic [DEPTH-1:0][DATA_W-1:0]   stored_d,
   input  logic [LANES-1:0]               enq_valid,
   input  logic [LANES-1:0][SEQ_W-1:0]    enq_seq,
   input  logic [LANES-1:0][DATA_W-1:0]   enq_data,
   output logic [DEPTH-1:0]               merged_v,
   output logic [DEPTH-1:0][DATA_W-1:0]   merged_d
);
   always_comb begin
      merged_v = stored_v;
      merged_d = stored_d;
      for (int l = 0; l < LANES; l++) begin
         if (enq_valid[l]) begin
            merged_v[enq_seq[l][IDX_W-1:0]] = 1'b1;
            merged_d[enq_seq[l][IDX_W-1:0]] = enq_data[l];
         end
      end
   end

   // R2: arrivals must target free slots and never collide within a cycle
   for (genvar l = 0; l < LANES; l++) begin : g_chk
      a_r2_slot_free : assert property (@(posedge clk) disable iff (rst)
         enq_valid[l] |-> !stored_v[enq_seq[l][IDX_W-1:0]]);
      for (genvar m = l + 1; m < LANES; m++) begin : g_pair
         a_r2_no_collide : assert property (@(posedge clk) disable iff (rst)
            (enq_valid[l] && enq_valid[m]) |->
               (enq_seq[l][IDX_W-1:0] != enq_seq[m][IDX_W-1:0]));
      end
   end
endmodule

// File: rtl/rob_run_detect.sv
module rob_run_detect #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned LANES = 3,
   localparam int unsigned IDX_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(LANES + 1),
   localparam int unsigned LEN_W = $clog2(DEPTH + 1)
) (
   input  logic [IDX_W-1:0] head,
   input  logic [DEPTH-1:0] merged_v,
   output logic [LANES-1:0] take,
   output logic [CNT_W-1:0] take_cnt
);
   logic [DEPTH-1:0] rot;
   logic [DEPTH-1:0] fall;
   logic [LEN_W-1:0] run_len;

   // rotate so bit 0 is the head slot; wrap is free because DEPTH is a power of two
   always_comb begin
      for (int i = 0; i < DEPTH; i++)
         rot[i] = merged_v[head + IDX_W'(i)];
   end

   // falling edges, with a virtual '1' below bit 0
   always_comb begin
      fall[0] = ~rot[0];
      for (int i = 1; i < DEPTH; i++)
         fall[i] = rot[i-1] & ~rot[i];
   end

   // lowest edge is the first missing slot
   always_comb begin
      run_len = LEN_W'(DEPTH);
      for (int i = DEPTH - 1; i >= 0; i--)
         if (fall[i]) run_len = LEN_W'(i);
   end

   always_comb begin
      for (int j = 0; j < LANES; j++)
         take[j] = (LEN_W'(j) < run_len);
   end

   if (LANES == DEPTH) begin : g_full
      assign take_cnt = CNT_W'(run_len);
   end else begin : g_capped
      assign take_cnt = (run_len > LEN_W'(LANES)) ? CNT_W'(LANES) : CNT_W'(run_len);
   end
endmodule

// File: rtl/rob_bypass.sv
module rob_bypass
   import rob_pkg::*;
#(
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned LANES  = 3,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SEQ_W  = 4,
   localparam int unsigned IDX_W  = $clog2(DEPTH),
   localparam int unsigned CNT_W  = $clog2(LANES + 1),
   localparam int unsigned FREE_W = $clog2(DEPTH + 1)
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [LANES-1:0]              enq_valid,
   input  logic [LANES-1:0][SEQ_W-1:0]   enq_seq,
   input  logic [LANES-1:0][DATA_W-1:0]  enq_data,
   output logic [LANES-1:0]              cmt_valid,
   output logic [LANES-1:0][DATA_W-1:0]  cmt_data,
   output logic [CNT_W-1:0]              cmt_count,
   output logic [FREE_W-1:0]             free_slots
);
   if (!is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
      $error("rob_bypass: DEPTH must be a power of two >= 2");
   end
   if (LANES < 1 || LANES > DEPTH) begin : g_bad_lanes
      $error("rob_bypass: LANES must be in 1..DEPTH");
   end
   if (SEQ_W < IDX_W) begin : g_bad_seq
      $error("rob_bypass: SEQ_W narrower than slot index");
   end

   logic [DEPTH-1:0]              valid_q, valid_d, merged_v;
   logic [DEPTH-1:0][DATA_W-1:0]  data_q, merged_d;
   logic [IDX_W-1:0]              head_q;
   logic [LANES-1:0]              take;
   logic [CNT_W-1:0]              take_cnt;
   logic [CNT_W-1:0]              enq_cnt;
   logic                          started_q;

   rob_shadow #(.DEPTH(DEPTH), .LANES(LANES), .DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_shadow (
      .clk(clk), .rst(rst),
      .stored_v(valid_q), .stored_d(data_q),
      .enq_valid(enq_valid), .enq_seq(enq_seq), .enq_data(enq_data),
      .merged_v(merged_v), .merged_d(merged_d)
   );

   rob_run_detect #(.DEPTH(DEPTH), .LANES(LANES)) u_run (
      .head(head_q), .merged_v(merged_v), .take(take), .take_cnt(take_cnt)
   );

   for (genvar k = 0; k < LANES; k++) begin : g_out
      assign cmt_valid[k] = take[k];
      assign cmt_data[k]  = merged_d[head_q + IDX_W'(k)];
   end
   assign cmt_count = take_cnt;

   always_comb begin
      valid_d = merged_v;
      for (int k = 0; k < LANES; k++)
         if (take[k]) valid_d[head_q + IDX_W'(k)] = 1'b0;
   end

   always_comb begin
      free_slots = '0;
      for (int i = 0; i < DEPTH; i++)
         free_slots = free_slots + FREE_W'(!valid_q[i]);
   end

   always_comb begin
      enq_cnt = '0;
      for (int l = 0; l < LANES; l++)
         enq_cnt = enq_cnt + CNT_W'(enq_valid[l]);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q   <= '0;
         head_q    <= '0;
         started_q <= 1'b0;
      end else begin
         valid_q   <= valid_d;
         head_q    <= head_q + IDX_W'(take_cnt);
         started_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) data_q <= merged_d;

   a_r1_reset_empty : assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (free_slots == FREE_W'(DEPTH)));

   a_r9_free_track : assert property (@(posedge clk) disable iff (rst || !started_q)
      int'(free_slots) == int'($past(free_slots)) - int'($past(enq_cnt)) + int'($past(cmt_count)));

   for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
      a_r4_from_valid : assert property (@(posedge clk) disable iff (rst)
         cmt_valid[k] |-> merged_v[head_q + IDX_W'(k)]);
      if (k > 0) begin : g_pack
         a_r3_packed : assert property (@(posedge clk) disable iff (rst)
            cmt_valid[k] |-> cmt_valid[k-1]);
      end
   end
endmodule

// File: tb/rob_bypass_tb.sv
module rob_bypass_tb;
   localparam int N = 8, L = 3, DW = 8, SW = 4;
   localparam int IW = $clog2(N);

   logic clk = 1'b0, rst = 1'b1;
   logic [L-1:0]          enq_valid;
   logic [L-1:0][SW-1:0]  enq_seq;
   logic [L-1:0][DW-1:0]  enq_data;
   logic [L-1:0]          cmt_valid;
   logic [L-1:0][DW-1:0]  cmt_data;
   logic [$clog2(L+1)-1:0] cmt_count;
   logic [$clog2(N+1)-1:0] free_slots;

   int errors = 0, checks = 0;
   bit m_v [N];
   logic [DW-1:0] m_d [N];
   int m_ptr = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   rob_bypass #(.DEPTH(N), .LANES(L), .DATA_W(DW), .SEQ_W(SW)) u_dut (
      .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_seq(enq_seq), .enq_data(enq_data),
      .cmt_valid(cmt_valid), .cmt_data(cmt_data), .cmt_count(cmt_count), .free_slots(free_slots)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int used_count();
      int c = 0;
      for (int i = 0; i < N; i++) c += m_v[i];
      return c;
   endfunction

   task automatic clear_enq();
      enq_valid = '0; enq_seq = '0; enq_data = '0;
   endtask

   task automatic put(input int lane, input int slot, input logic [DW-1:0] d);
      enq_valid[lane] = 1'b1;
      enq_seq[lane]   = {SW'($urandom % 2) << IW} | SW'(slot); // R2 upper bits ignored
      enq_data[lane]  = d;
   endtask

   // evaluate current inputs against the model, then advance the model
   task automatic step();
      bit sv [N];
      bit fresh [N];
      logic [DW-1:0] sd [N];
      int k;
      #1;
      for (int i = 0; i < N; i++) begin sv[i] = m_v[i]; sd[i] = m_d[i]; fresh[i] = 0; end
      for (int l = 0; l < L; l++)
         if (enq_valid[l]) begin
            sv[enq_seq[l][IW-1:0]] = 1; sd[enq_seq[l][IW-1:0]] = enq_data[l];
            fresh[enq_seq[l][IW-1:0]] = 1;
         end
      k = 0;
      while (k < L && sv[(m_ptr + k) % N]) k++;
      check(int'(free_slots) == N - used_count(), "R9 R10 free_slots", int'(free_slots), N - used_count());
      check(int'(cmt_count) == k, "R5 R8 cmt_count", int'(cmt_count), k);
      for (int j = 0; j < L; j++) begin
         int s = (m_ptr + j) % N;
         check(cmt_valid[j] == (j < k), "R3 R4 cmt_valid lane", int'(cmt_valid[j]), int'(j < k));
         if (j < k) begin
            if (m_ptr + j >= N)
               check(cmt_data[j] == sd[s], "R7 wrap data", int'(cmt_data[j]), int'(sd[s]));
            else if (fresh[s])
               check(cmt_data[j] == sd[s], "R6 bypass data", int'(cmt_data[j]), int'(sd[s]));
            else
               check(cmt_data[j] == sd[s], "R2 stored data", int'(cmt_data[j]), int'(sd[s]));
         end
      end
      for (int j = 0; j < k; j++) sv[(m_ptr + j) % N] = 0;
      for (int i = 0; i < N; i++) begin m_v[i] = sv[i]; m_d[i] = sd[i]; end
      m_ptr = (m_ptr + k) % N;
      @(negedge clk);
   endtask

   task automatic rand_enq();
      bit taken [N];
      clear_enq();
      for (int i = 0; i < N; i++) taken[i] = 0;
      for (int l = 0; l < L; l++) begin
         if ($urandom % 4 != 0) begin
            int s = $urandom % N;
            if (!m_v[s] && !taken[s]) begin
               taken[s] = 1;
               put(l, s, DW'($urandom));
            end
         end
      end
   endtask

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < N; i++) begin m_v[i] = 0; m_d[i] = '0; end
      clear_enq();
      repeat (3) @(negedge clk);
      #1;
      check(int'(free_slots) == N, "R1 reset free_slots", int'(free_slots), N);
      check(cmt_valid == '0, "R1 reset no retire", int'(cmt_valid), 0);
      rst = 1'b0;
      @(negedge clk);
      // R4 gap at head blocks retire
      clear_enq(); put(0, 1, 8'hA1); step();
      // R6 head arrives, retires with its neighbour; R2 upper bits random
      clear_enq(); put(2, 0, 8'hB0); step();
      // R6 three arrivals retire at once
      clear_enq(); put(0, 2, 8'h22); put(1, 3, 8'h33); put(2, 4, 8'h44); step();
      clear_enq(); put(1, 5, 8'h55); step();
      // R7 run across the wrap
      clear_enq(); put(0, 7, 8'h77); put(1, 0, 8'h10); put(2, 1, 8'h11); step();
      clear_enq(); put(2, 6, 8'h66); step();
      clear_enq(); step();
      check(m_ptr == 2, "R8 head pointer after wrap", m_ptr, 2);
      for (int c = 0; c < 3000; c++) begin
         rand_enq();
         step();
      end
      clear_enq();
      repeat (4) step();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule